// File: doc/BRIEF.md
# Lock-Aware Loop Output Clock Selector

This block chooses the clock that leaves a frequency-locked loop. It can pass the loop's reference clock, the loop's oscillator clock, or no clock at all. The choice comes from a 2-bit mode field and the loop's lock indicator. Two of the modes ignore the lock indicator and force one source. The other two follow it. One of these falls back to the reference clock while unlocked. The other holds the output low until lock is reached.

Every switch is break-before-make. The enable of each source is resynchronized into that source's own clock domain and changes only while that clock is low. The old source is fully disabled before the new one is requested. The output therefore never carries a shortened pulse or a merged pulse from both clocks.

A mode write raises a pending flag. The flag stays high until the new selection is active, as seen back in the reference domain, and until a minimum number of reference cycles has passed. Software polls this flag to confirm that a change has taken effect. A status code reports the source that is currently active.

Top module: `fll_bypass_mux`

## Requirements
- R1: After reset the mode is automatic (code 0), the pending flag is low, the status reads 0 and the output is low; once reset is released with lock low, the reference clock is selected.
- R2: Mode code 0 outputs the reference clock while lock is low and the oscillator clock while lock is high.
- R3: Mode code 1 outputs the oscillator clock while lock is high and holds the output low (no clock) while lock is low.
- R4: Mode code 2 outputs the reference clock whatever the lock level.
- R5: Mode code 3 outputs the oscillator clock whatever the lock level.
- R6: The two sources are never enabled together. Every high pulse on the output is a complete high phase of exactly one source clock.
- R7: No low phase on the output is shorter than the shorter low phase of the two source clocks, including across switches.
- R8: A mode write raises the pending flag on the next reference edge. The flag clears only after at least MIN_HOLD reference cycles and only once the selection for the written mode is active.
- R9: The status reads 0 when no source is active, 1 when the reference clock is active and 2 when the oscillator clock is active. It never reads 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Loop reference clock; also clocks the mode register and status |
| oscClk | input | 1 | Loop oscillator output clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lockIn | input | 1 | Lock indicator, asynchronous to both clocks |
| modeIn | input | 2 | Mode code: 0 auto, 1 locked-or-none, 2 force reference, 3 force oscillator |
| modeWr | input | 1 | Write strobe for modeIn, sampled on refClk |
| clkOut | output | 1 | Selected, gated output clock |
| selStatus | output | 2 | Active source: 0 none, 1 reference, 2 oscillator |
| changePending | output | 1 | High from a mode write until the new selection is in effect |

## Verification
The bench targets switches between the two clocks in both directions. A selector that enabled the new source before the old one was off would put a merged pulse on the output, and the pulse-width monitor flags it as a high phase of the wrong length. The locked-or-none mode is driven with lock low. A design that fell back to the reference clock there would show about 26 output edges in the window where none are allowed. The bench also writes a mode that is already active, which checks that the pending flag still lasts the minimum hold. It toggles lock in the forcing modes, where a selector that wrongly followed lock would change the edge count.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    MODE_AUTO      = 2'd0,
    MODE_LOCK_GATE = 2'd1,
    MODE_REF       = 2'd2,
    MODE_OSC       = 2'd3
  } modeT;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REF  = 2'd1,
    SRC_OSC  = 2'd2
  } srcT;

  // Request from control to datapath, one strobe per source.
  typedef struct packed {
    logic wantOsc;
    logic wantRef;
  } selReqT;

  function automatic srcT pickSrc(input modeT mode, input logic locked);
    case (mode)
      MODE_AUTO:      pickSrc = locked ? SRC_OSC : SRC_REF;
      MODE_LOCK_GATE: pickSrc = locked ? SRC_OSC : SRC_NONE;
      MODE_REF:       pickSrc = SRC_REF;
      default:        pickSrc = SRC_OSC;
    endcase
  endfunction

endpackage

// File: rtl/fbp_sync.sv
module fbp_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD    = 5
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       lockIn,
  input  logic [1:0] modeIn,
  input  logic       modeWr,
  input  logic [1:0] srcEn,
  output selReqT     selReq,
  output modeT       curMode,
  output logic [1:0] selStatus,
  output logic       changePending
);

  localparam int CW = $clog2(MIN_HOLD + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(MIN_HOLD);

  logic       lockSync;
  logic [1:0] enSync;
  modeT       modeQ;
  srcT        wantSrc;
  srcT        activeSrc;
  logic       pendQ;
  logic [CW-1:0] holdCnt;

  fbp_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_lockSync (
    .clk(refClk), .rstN(rstN), .d(lockIn), .q(lockSync)
  );

  // Enables come back from both domains; resample them in the reference domain.
  fbp_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_SRC)) u_enSync (
    .clk(refClk), .rstN(rstN), .d(srcEn), .q(enSync)
  );

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_AUTO;
    end else if (modeWr) begin
      modeQ <= modeT'(modeIn);
    end
  end

  assign wantSrc = pickSrc(modeQ, lockSync);

  always_comb begin
    if (enSync[1])      activeSrc = SRC_OSC;
    else if (enSync[0]) activeSrc = SRC_REF;
    else                activeSrc = SRC_NONE;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= 1'b0;
      holdCnt <= '0;
    end else if (modeWr) begin
      pendQ   <= 1'b1;
      holdCnt <= '0;
    end else if (pendQ) begin
      if (holdCnt != HOLD_LAST) begin
        holdCnt <= holdCnt + 1'b1;
      end else if (activeSrc == wantSrc) begin
        pendQ <= 1'b0;
      end
    end
  end

  assign selReq.wantRef = (wantSrc == SRC_REF);
  assign selReq.wantOsc = (wantSrc == SRC_OSC);
  assign curMode        = modeQ;
  assign selStatus      = activeSrc;
  assign changePending  = pendQ;

endmodule

// File: rtl/fbp_datapath.sv
module fbp_datapath
  import fbp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               refClk,
  input  logic               oscClk,
  input  logic               rstN,
  input  selReqT             selReq,
  output logic               clkOut,
  output logic [NUM_SRC-1:0] srcEn
);

  logic [NUM_SRC-1:0] clkVec;
  logic [NUM_SRC-1:0] wantVec;
  logic [NUM_SRC-1:0] gated;

  assign clkVec  = {oscClk, refClk};
  assign wantVec = {selReq.wantOsc, selReq.wantRef};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ch
    logic reqRaw;
    logic reqSync;
    logic enQ;

    // Ask for this source only once the other one is off.
    assign reqRaw = wantVec[i] & ~srcEn[NUM_SRC-1-i];

    fbp_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_reqSync (
      .clk(clkVec[i]), .rstN(rstN), .d(reqRaw), .q(reqSync)
    );

    // Enable moves only while this clock is low.
    always_ff @(negedge clkVec[i] or negedge rstN) begin
      if (!rstN) enQ <= 1'b0;
      else       enQ <= reqSync;
    end

    assign srcEn[i] = enQ;
    assign gated[i] = clkVec[i] & enQ;
  end

  assign clkOut = |gated;

endmodule

// File: rtl/fll_bypass_mux.sv
module fll_bypass_mux
  import fbp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD    = 5
) (
  input  logic       refClk,
  input  logic       oscClk,
  input  logic       rstN,
  input  logic       lockIn,
  input  logic [1:0] modeIn,
  input  logic       modeWr,
  output logic       clkOut,
  output logic [1:0] selStatus,
  output logic       changePending
);

  selReqT             selReq;
  modeT               curMode;
  logic [NUM_SRC-1:0] srcEn;

  fbp_ctrl #(.SYNC_STAGES(SYNC_STAGES), .MIN_HOLD(MIN_HOLD)) u_ctrl (
    .refClk(refClk), .rstN(rstN), .lockIn(lockIn), .modeIn(modeIn),
    .modeWr(modeWr), .srcEn(srcEn), .selReq(selReq), .curMode(curMode),
    .selStatus(selStatus), .changePending(changePending)
  );

  fbp_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .refClk(refClk), .oscClk(oscClk), .rstN(rstN), .selReq(selReq),
    .clkOut(clkOut), .srcEn(srcEn)
  );

endmodule

// File: rtl/fbp_chk.sv
module fbp_chk (
  input logic       refClk,
  input logic       rstN,
  input logic       modeWr,
  input logic       changePending,
  input logic [1:0] srcEn,
  input logic [1:0] selStatus,
  input logic [1:0] curMode
);

  // R6
  single_src_chk: assert property (@(posedge refClk) disable iff (!rstN)
    srcEn != 2'b11);

  // R8
  pend_set_chk: assert property (@(posedge refClk) disable iff (!rstN)
    modeWr |=> changePending);

  // R9
  status_code_chk: assert property (@(posedge refClk) disable iff (!rstN)
    selStatus != 2'b11);

  // R4
  force_ref_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (curMode == 2'd2 && !changePending) |-> selStatus == 2'd1);

  // R5
  force_osc_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (curMode == 2'd3 && !changePending) |-> selStatus == 2'd2);

endmodule

bind fll_bypass_mux fbp_chk u_chk (
  .refClk(refClk), .rstN(rstN), .modeWr(modeWr),
  .changePending(changePending), .srcEn(srcEn),
  .selStatus(selStatus), .curMode(curMode)
);

// File: tb/sim_fll_bypass_mux.sv
`timescale 1ns/1ps
module sim_fll_bypass_mux;

  localparam int MIN_HOLD = 5;
  localparam realtime REF_HALF = 5.0;
  localparam realtime OSC_HALF = 6.5;

  logic refClk = 1'b0;
  logic oscClk = 1'b0;
  logic rstN = 1'b0;
  logic lockIn = 1'b0;
  logic [1:0] modeIn = 2'd0;
  logic modeWr = 1'b0;
  logic clkOut;
  logic [1:0] selStatus;
  logic changePending;

  int nChecks = 0;
  int nFails = 0;
  int edgeCnt = 0;
  int badHigh = 0;
  int badLow = 0;
  realtime tRise = -100.0;
  realtime tFall = -100.0;
  bit done = 1'b0;

  always #(REF_HALF) refClk = ~refClk;
  initial begin
    #3;
    forever #(OSC_HALF) oscClk = ~oscClk;
  end

  fll_bypass_mux #(.MIN_HOLD(MIN_HOLD)) u0 (
    .refClk(refClk), .oscClk(oscClk), .rstN(rstN), .lockIn(lockIn),
    .modeIn(modeIn), .modeWr(modeWr), .clkOut(clkOut),
    .selStatus(selStatus), .changePending(changePending)
  );

  // Pulse-width monitor on the output clock.
  always @(posedge clkOut) begin
    edgeCnt++;
    if (tFall > 0.0 && ($realtime - tFall) < REF_HALF - 0.05) badLow++;
    tRise = $realtime;
  end
  always @(negedge clkOut) begin
    realtime w;
    w = $realtime - tRise;
    if (tRise > 0.0 &&
        !((w > REF_HALF - 0.05 && w < REF_HALF + 0.05) ||
          (w > OSC_HALF - 0.05 && w < OSC_HALF + 0.05))) badHigh++;
    tFall = $realtime;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expSrc(input int mode, input bit lock);
    case (mode)
      0: expSrc = lock ? 2 : 1;
      1: expSrc = lock ? 2 : 0;
      2: expSrc = 1;
      default: expSrc = 2;
    endcase
  endfunction

  task automatic waitRef(input int n);
    for (int k = 0; k < n; k++) @(negedge refClk);
  endtask

  // Counts output edges over 260 ns: 0 -> none, ~26 -> reference, ~20 -> oscillator.
  task automatic measure(output int src);
    int c0;
    int n;
    c0 = edgeCnt;
    #260;
    n = edgeCnt - c0;
    if (n == 0) src = 0;
    else if (n >= 24 && n <= 28) src = 1;
    else if (n >= 18 && n <= 22) src = 2;
    else src = 3;
  endtask

  task automatic writeMode(input int mode, input string req, output int pendSamples);
    @(negedge refClk);
    modeIn = mode[1:0];
    modeWr = 1'b1;
    @(negedge refClk);
    modeWr = 1'b0;
    chk(changePending == 1'b1, "R8 pending after write", int'(changePending), 1);
    pendSamples = 0;
    for (int k = 0; k < 200 && changePending; k++) begin
      pendSamples++;
      @(negedge refClk);
    end
    chk(changePending == 1'b0, {req, " pending clears"}, int'(changePending), 0);
  endtask

  task automatic checkSel(input int expV, input string req);
    int got;
    @(negedge refClk);
    chk(int'(selStatus) == expV, {req, " status"}, int'(selStatus), expV);
    measure(got);
    chk(got == expV, {req, " output source"}, got, expV);
  endtask

  initial begin
    int ps;
    void'($urandom(32'h5eed_0042));
    waitRef(3);
    // R1: reset state
    chk(selStatus == 2'd0, "R1 status in reset", int'(selStatus), 0);
    chk(changePending == 1'b0, "R1 pending in reset", int'(changePending), 0);
    chk(clkOut == 1'b0, "R1 output in reset", int'(clkOut), 0);
    rstN = 1'b1;
    waitRef(30);
    chk(changePending == 1'b0, "R1 pending after reset", int'(changePending), 0);
    checkSel(1, "R1 R2 auto unlocked");

    lockIn = 1'b1;
    waitRef(30);
    checkSel(2, "R2 auto locked");

    writeMode(1, "R3", ps);
    checkSel(2, "R3 gate-mode locked");
    lockIn = 1'b0;
    waitRef(30);
    chk(clkOut == 1'b0, "R3 output held low", int'(clkOut), 0);
    checkSel(0, "R3 gate-mode unlocked");
    lockIn = 1'b1;
    waitRef(30);
    checkSel(2, "R3 gate-mode relock");

    writeMode(2, "R4", ps);
    checkSel(1, "R4 force ref locked");
    lockIn = 1'b0;
    waitRef(30);
    checkSel(1, "R4 force ref unlocked");

    writeMode(3, "R5", ps);
    checkSel(2, "R5 force osc unlocked");
    lockIn = 1'b1;
    waitRef(30);
    checkSel(2, "R5 force osc locked");

    // R8: rewriting the active mode still holds pending for MIN_HOLD cycles
    writeMode(3, "R8", ps);
    chk(ps >= MIN_HOLD && ps <= MIN_HOLD + 2, "R8 hold length", ps, MIN_HOLD + 1);

    for (int it = 0; it < 24; it++) begin
      int m;
      bit lk;
      m = int'($urandom_range(0, 3));
      lk = 1'($urandom_range(0, 1));
      lockIn = lk;
      waitRef(6);
      writeMode(m, "R9 random", ps);
      checkSel(expSrc(m, lk), "R9 random");
    end

    chk(badHigh == 0, "R6 high pulse width", badHigh, 0);
    chk(badLow == 0, "R7 low pulse width", badLow, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule